// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Unit

This block keeps a small bank of token flags that two independent agents, a left port and a right port, use to arbitrate shared resources. Each port has a memory select, a semaphore select, a write strobe, a flag index and a data bus in each direction. A port touches the flags only in a cycle where its semaphore select is high and its memory select is low. In such a cycle a write with data bit 0 low asks for the indexed token, and a write with data bit 0 high gives it back.

A port that asks for a token the other side holds does not see any change at first. The request is stored, and when the holder gives the token back it passes directly to the waiting port without any retry. Reads are relative to the reading port: zero means "this port holds the token" and one means "it does not". The bit is copied onto every line of the read bus. The unit is kept separate from any storage array that sits next to it.

Top module: `dual_sem_unit`

## Requirements
- R1: A port acts on the flags only when its semaphore select is 1 and its memory select is 0. Any other combination changes no flag, and that port's read bus is all zeros.
- R2: The flag index picks one of NUM_SEMS flags (8 by default, index 0 to 7). Each flag changes only through accesses that carry its own index.
- R3: A write looks only at data bit 0, where 0 means request and 1 means release. Bits 15 to 1 are ignored.
- R4: During a read cycle (access with write strobe 0), the read bus shows the flag as seen by that port, on all 16 bits. The value is 16'h0000 if that port holds the token and 16'hFFFF otherwise. It reflects the writes of earlier cycles.
- R5: A request to a free flag gives the token to the requester from the next cycle on. The requester then reads 16'h0000 and the other port reads 16'hFFFF.
- R6: A request from the port that does not hold the token leaves both readbacks unchanged and records that request as pending.
- R7: A release by the holder while the other port has a request pending, or while the other port requests in the same cycle, hands the token to the other port, so the two readbacks swap.
- R8: A release by the holder with nothing pending from the other port makes the flag free, so both ports read 16'hFFFF.
- R9: A pending requester that writes a release before it is granted withdraws its request. A later release by the holder then frees the flag.
- R10: If both ports request a free flag in the same cycle, the left port gets the token and the right request stays pending.
- R11: After reset all flags are free and nothing is pending.
- R12: A request from the holder, or a release from a port with no token and no pending request, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lMemSel | input | 1 | Left memory select; when high it blocks flag access |
| lSemSel | input | 1 | Left semaphore select |
| lWrEn | input | 1 | Left write strobe (1 = write, 0 = read) |
| lIdx | input | 3 | Left flag index |
| lWrData | input | 16 | Left write data; only bit 0 is used |
| lRdData | output | 16 | Left readback |
| rMemSel | input | 1 | Right memory select; when high it blocks flag access |
| rSemSel | input | 1 | Right semaphore select |
| rWrEn | input | 1 | Right write strobe (1 = write, 0 = read) |
| rIdx | input | 3 | Right flag index |
| rWrData | input | 16 | Right write data; only bit 0 is used |
| rRdData | output | 16 | Right readback |

## Verification
The bench builds the unit with its default parameters: eight flags and a 16-bit bus. Eight flags are few enough that random traffic on both ports often lands on the same index. That makes same-cycle collisions, handovers with pending requests and withdrawals happen many times, alongside the directed sequences. The full bus width lets the bench check that the upper write bits have no effect and that the readback is replicated on every line.

// File: rtl/sem_pkg.sv
package sem_pkg;

  typedef enum logic [1:0] {
    OWN_FREE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } ownerState_t;

  typedef struct packed {
    logic take;
    logic drop;
    logic look;
  } portStb_t;

endpackage

// File: rtl/sem_ctrl.sv
module sem_ctrl (
  input  logic              lMemSel,
  input  logic              lSemSel,
  input  logic              lWrEn,
  input  logic              lBit,
  input  logic              rMemSel,
  input  logic              rSemSel,
  input  logic              rWrEn,
  input  logic              rBit,
  output sem_pkg::portStb_t lStb,
  output sem_pkg::portStb_t rStb
);

  localparam int PORTS = 2;

  logic [PORTS-1:0] memSel, semSel, wrEn, wrBit;
  sem_pkg::portStb_t stb [PORTS];

  assign memSel = {rMemSel, lMemSel};
  assign semSel = {rSemSel, lSemSel};
  assign wrEn   = {rWrEn, lWrEn};
  assign wrBit  = {rBit, lBit};

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    logic active;
    assign active      = semSel[p] & ~memSel[p];
    assign stb[p].take = active & wrEn[p] & ~wrBit[p];
    assign stb[p].drop = active & wrEn[p] & wrBit[p];
    assign stb[p].look = active & ~wrEn[p];
  end

  assign lStb = stb[0];
  assign rStb = stb[1];

endmodule

// File: rtl/sem_flags.sv
module sem_flags #(
  parameter int NUM_SEMS = 8,
  parameter int IDX_W    = 3,
  parameter int DATA_W   = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  sem_pkg::portStb_t     lStb,
  input  sem_pkg::portStb_t     rStb,
  input  logic [IDX_W-1:0]      lIdx,
  input  logic [IDX_W-1:0]      rIdx,
  output logic [DATA_W-1:0]     lRdData,
  output logic [DATA_W-1:0]     rRdData,
  output logic [2*NUM_SEMS-1:0] ownerFlat
);
  import sem_pkg::*;

  for (genvar g = 0; g < NUM_SEMS; g++) begin : g_flag
    ownerState_t ownQ, ownD;
    logic pendLQ, pendRQ, pendLD, pendRD;
    logic lTake, lDrop, rTake, rDrop;
    logic pendL, pendR;

    assign lTake = lStb.take & (lIdx == IDX_W'(g));
    assign lDrop = lStb.drop & (lIdx == IDX_W'(g));
    assign rTake = rStb.take & (rIdx == IDX_W'(g));
    assign rDrop = rStb.drop & (rIdx == IDX_W'(g));

    always_comb begin
      pendL  = lTake ? 1'b1 : (lDrop ? 1'b0 : pendLQ);
      pendR  = rTake ? 1'b1 : (rDrop ? 1'b0 : pendRQ);
      ownD   = ownQ;
      pendLD = 1'b0;
      pendRD = 1'b0;
      case (ownQ)
        OWN_FREE: begin
          if (lTake) begin
            ownD   = OWN_LEFT;
            pendRD = rTake;
          end else if (rTake) begin
            ownD = OWN_RIGHT;
          end
        end
        OWN_LEFT: begin
          if (lDrop) ownD = pendR ? OWN_RIGHT : OWN_FREE;
          else       pendRD = pendR;
        end
        OWN_RIGHT: begin
          if (rDrop) ownD = pendL ? OWN_LEFT : OWN_FREE;
          else       pendLD = pendL;
        end
        default: ownD = OWN_FREE;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ownQ   <= OWN_FREE;
        pendLQ <= 1'b0;
        pendRQ <= 1'b0;
      end else begin
        ownQ   <= ownD;
        pendLQ <= pendLD;
        pendRQ <= pendRD;
      end
    end

    assign ownerFlat[2*g +: 2] = ownQ;
  end

  ownerState_t lSeen, rSeen;

  always_comb begin
    lSeen = OWN_FREE;
    rSeen = OWN_FREE;
    for (int i = 0; i < NUM_SEMS; i++) begin
      if (lIdx == IDX_W'(i)) lSeen = ownerState_t'(ownerFlat[2*i +: 2]);
      if (rIdx == IDX_W'(i)) rSeen = ownerState_t'(ownerFlat[2*i +: 2]);
    end
  end

  assign lRdData = lStb.look ? {DATA_W{lSeen != OWN_LEFT}}  : '0;
  assign rRdData = rStb.look ? {DATA_W{rSeen != OWN_RIGHT}} : '0;

endmodule

// File: rtl/dual_sem_unit.sv
module dual_sem_unit #(
  parameter int NUM_SEMS = 8,
  parameter int DATA_W   = 16,
  localparam int IDX_W   = $clog2(NUM_SEMS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lMemSel,
  input  logic              lSemSel,
  input  logic              lWrEn,
  input  logic [IDX_W-1:0]  lIdx,
  input  logic [DATA_W-1:0] lWrData,
  output logic [DATA_W-1:0] lRdData,
  input  logic              rMemSel,
  input  logic              rSemSel,
  input  logic              rWrEn,
  input  logic [IDX_W-1:0]  rIdx,
  input  logic [DATA_W-1:0] rWrData,
  output logic [DATA_W-1:0] rRdData
);

  sem_pkg::portStb_t lStb, rStb;
  logic [2*NUM_SEMS-1:0] ownerFlat;
  logic unusedHighBits;

  assign unusedHighBits = ^{lWrData[DATA_W-1:1], rWrData[DATA_W-1:1]};

  sem_ctrl i_ctrl (
    .lMemSel (lMemSel),
    .lSemSel (lSemSel),
    .lWrEn   (lWrEn),
    .lBit    (lWrData[0]),
    .rMemSel (rMemSel),
    .rSemSel (rSemSel),
    .rWrEn   (rWrEn),
    .rBit    (rWrData[0]),
    .lStb    (lStb),
    .rStb    (rStb)
  );

  sem_flags #(
    .NUM_SEMS (NUM_SEMS),
    .IDX_W    (IDX_W),
    .DATA_W   (DATA_W)
  ) i_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .lStb      (lStb),
    .rStb      (rStb),
    .lIdx      (lIdx),
    .rIdx      (rIdx),
    .lRdData   (lRdData),
    .rRdData   (rRdData),
    .ownerFlat (ownerFlat)
  );

endmodule

// File: rtl/dual_sem_unit_chk.sv
module dual_sem_unit_chk #(
  parameter int NUM_SEMS = 8,
  parameter int DATA_W   = 16,
  localparam int IDX_W   = $clog2(NUM_SEMS)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  lMemSel,
  input logic                  lSemSel,
  input logic                  lWrEn,
  input logic [IDX_W-1:0]      lIdx,
  input logic [DATA_W-1:0]     lWrData,
  input logic [DATA_W-1:0]     lRdData,
  input logic                  rMemSel,
  input logic                  rSemSel,
  input logic                  rWrEn,
  input logic [IDX_W-1:0]      rIdx,
  input logic [DATA_W-1:0]     rWrData,
  input logic [DATA_W-1:0]     rRdData,
  input logic [2*NUM_SEMS-1:0] ownerFlat
);

  logic lAct, rAct, lTake, lDrop, rTake, lRead, rRead;
  assign lAct  = lSemSel & ~lMemSel;
  assign rAct  = rSemSel & ~rMemSel;
  assign lTake = lAct & lWrEn & ~lWrData[0];
  assign lDrop = lAct & lWrEn & lWrData[0];
  assign rTake = rAct & rWrEn & ~rWrData[0];
  assign lRead = lAct & ~lWrEn;
  assign rRead = rAct & ~rWrEn;

  function automatic logic [1:0] ownAt(input logic [IDX_W-1:0] i);
    return ownerFlat[i*2 +: 2];
  endfunction

  assert_idle_bus_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!lRead) |-> (lRdData == '0));

  assert_read_replicated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lRead |-> (lRdData == '0 || lRdData == '1));

  assert_free_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lTake && ownAt(lIdx) == 2'd0) |=> (ownerFlat[$past(lIdx)*2 +: 2] == 2'd1));

  assert_loser_no_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rTake && ownAt(rIdx) == 2'd1 && !(lDrop && lIdx == rIdx))
      |=> (ownerFlat[$past(rIdx)*2 +: 2] == 2'd1));

  assert_release_leaves_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lDrop && ownAt(lIdx) == 2'd1) |=> (ownerFlat[$past(lIdx)*2 +: 2] != 2'd1));

  assert_single_holder_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lRead && rRead && lIdx == rIdx) |-> !(lRdData == '0 && rRdData == '0));

endmodule

bind dual_sem_unit dual_sem_unit_chk #(.NUM_SEMS(NUM_SEMS), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/test_dual_sem_unit.sv
`timescale 1ns/1ps
module test_dual_sem_unit;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lMemSel = 0, lSemSel = 0, lWrEn = 0, rMemSel = 0, rSemSel = 0, rWrEn = 0;
  logic [2:0] lIdx = 0, rIdx = 0;
  logic [15:0] lWrData = 0, rWrData = 0;
  logic [15:0] lRdData, rRdData;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int own [8];
  bit pendL [8];
  bit pendR [8];

  always #4 clk = ~clk;

  dual_sem_unit i_dual_sem_unit (
    .clk(clk), .rst_n(rst_n),
    .lMemSel(lMemSel), .lSemSel(lSemSel), .lWrEn(lWrEn), .lIdx(lIdx),
    .lWrData(lWrData), .lRdData(lRdData),
    .rMemSel(rMemSel), .rSemSel(rSemSel), .rWrEn(rWrEn), .rIdx(rIdx),
    .rWrData(rWrData), .rRdData(rRdData)
  );

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic checkVal(input string tag, input string what,
                          input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit lm, input bit ls, input bit lw, input int li,
                      input logic [15:0] ld, input bit rm, input bit rs,
                      input bit rw, input int ri, input logic [15:0] rd,
                      input string tag);
    bit la, ra;
    logic [15:0] le, re;
    lMemSel = lm; lSemSel = ls; lWrEn = lw; lIdx = 3'(li); lWrData = ld;
    rMemSel = rm; rSemSel = rs; rWrEn = rw; rIdx = 3'(ri); rWrData = rd;
    la = ls && !lm;
    ra = rs && !rm;
    le = (la && !lw) ? ((own[li] == 1) ? 16'h0000 : 16'hFFFF) : 16'h0000;
    re = (ra && !rw) ? ((own[ri] == 2) ? 16'h0000 : 16'hFFFF) : 16'h0000;
    #1;
    checkVal(tag, "left read", lRdData, le);
    checkVal(tag, "right read", rRdData, re);
    @(posedge clk);
    for (int k = 0; k < 8; k++) begin
      bit lt, lr, rt, rr, wantL, wantR;
      lt = la && lw && !ld[0] && li == k;
      lr = la && lw &&  ld[0] && li == k;
      rt = ra && rw && !rd[0] && ri == k;
      rr = ra && rw &&  rd[0] && ri == k;
      wantL = lt ? 1 : (lr ? 0 : pendL[k]);
      wantR = rt ? 1 : (rr ? 0 : pendR[k]);
      if (own[k] == 0) begin
        pendL[k] = 0; pendR[k] = 0;
        if (lt) begin own[k] = 1; pendR[k] = rt; end
        else if (rt) own[k] = 2;
      end else if (own[k] == 1) begin
        pendL[k] = 0;
        if (lr) begin own[k] = wantR ? 2 : 0; pendR[k] = 0; end
        else pendR[k] = wantR;
      end else begin
        pendR[k] = 0;
        if (rr) begin own[k] = wantL ? 1 : 0; pendL[k] = 0; end
        else pendL[k] = wantL;
      end
    end
    @(negedge clk);
  endtask

  // shorthand helpers: left/right write, both read
  task automatic lw0(input int i, input string t); step(0,1,1,i,16'h0000, 0,0,0,0,0, t); endtask
  task automatic lw1(input int i, input string t); step(0,1,1,i,16'h0001, 0,0,0,0,0, t); endtask
  task automatic rw0(input int i, input string t); step(0,0,0,0,0, 0,1,1,i,16'h0000, t); endtask
  task automatic rw1(input int i, input string t); step(0,0,0,0,0, 0,1,1,i,16'h0001, t); endtask
  task automatic rdBoth(input int i, input string t); step(0,1,0,i,16'h0, 0,1,0,i,16'h0, t); endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    for (int k = 0; k < 8; k++) begin own[k] = 0; pendL[k] = 0; pendR[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: reset state, every flag free on both ports
    for (int k = 0; k < 8; k++) rdBoth(k, "R11");

    // R5: take a free flag
    lw0(3, "R5"); rdBoth(3, "R5");
    // R2: other flags untouched
    rdBoth(2, "R2"); rdBoth(4, "R2");
    // R6: losing request leaves readback unchanged
    rw0(3, "R6"); rdBoth(3, "R6");
    // R12: holder re-requests, no change
    lw0(3, "R12"); rdBoth(3, "R12");
    // R7: release hands over to pending right
    lw1(3, "R7"); rdBoth(3, "R7");
    // R6: left now pending behind right
    lw0(3, "R6"); rdBoth(3, "R6");
    // R7: right releases, left gets it
    rw1(3, "R7"); rdBoth(3, "R7");
    // R8: release with nothing pending frees
    lw1(3, "R8"); rdBoth(3, "R8");
    // R12: release from non-holder on free flag
    rw1(3, "R12"); rdBoth(3, "R12");

    // R9: pending right withdraws
    lw0(5, "R9"); rw0(5, "R9"); rw1(5, "R9"); rdBoth(5, "R9");
    lw1(5, "R9"); rdBoth(5, "R9");

    // R10: simultaneous request on a free flag
    step(0,1,1,1,16'h0000, 0,1,1,1,16'h0000, "R10"); rdBoth(1, "R10");
    lw1(1, "R10"); rdBoth(1, "R10");
    rw1(1, "R10"); rdBoth(1, "R10");

    // R7: same-cycle release and request hands over
    lw0(6, "R7");
    step(0,1,1,6,16'h0001, 0,1,1,6,16'h0000, "R7"); rdBoth(6, "R7");
    rw1(6, "R7"); rdBoth(6, "R7");

    // R3: upper data bits ignored
    step(0,1,1,0,16'hFFFE, 0,0,0,0,0, "R3"); rdBoth(0, "R3");
    step(0,1,1,0,16'h0001, 0,0,0,0,0, "R3"); rdBoth(0, "R3");

    // R1: memory select or no semaphore select blocks access
    step(1,1,1,2,16'h0000, 0,0,1,2,16'h0000, "R1"); rdBoth(2, "R1");
    step(1,1,0,2,16'h0000, 1,1,0,2,16'h0000, "R1");

    // R4: random traffic on both ports
    for (int n = 0; n < 3000; n++) begin
      step($urandom_range(0,3) == 0, $urandom_range(0,3) != 0, 1'($urandom),
           int'($urandom_range(0,7)), 16'($urandom),
           $urandom_range(0,3) == 0, $urandom_range(0,3) != 0, 1'($urandom),
           int'($urandom_range(0,7)), 16'($urandom), "R4");
    end

    finishRun();
  end

endmodule